// File: doc/BRIEF.md
# Dual-Lane Serial Sample Receiver

This block receives sample words from an external tuner that acts as the bus master. The tuner drives a serial clock, one sync line and up to two data lines. The receiver is a pure listener. Both data lanes are timed by the same clock and sync, so one timing controller decides when a bit is taken. Each lane then shifts its own bits into its own word and emits its own stream of finished words.

All four serial inputs are oversampled by the system clock `clk` through two-stage synchronizers, and serial-clock edges are found by comparing successive samples. Each serial-clock level must therefore last at least three `clk` cycles. Sync and data must be stable for two `clk` cycles on either side of every serial-clock edge at which they are read. Sync is read only on rising serial-clock edges. Data is read on either edge, because start delays are set in half-cycle steps.

The word outputs are valid-only streams with no ready signal, since the serial source cannot be stalled. Each finished word is shown for exactly one `clk` cycle, and the sink must take it in that cycle. The configuration inputs are static and may only be changed while reset is held. Suggested tie-offs are word-select mode, MSB first, rising marker, a start delay code of 2 and an end guard code of 0.

Top module: `serial_sample_rx`

## Requirements
- R1: With `i_mode_lr`=0 (frame-pulse mode), a frame starts only at the marker transition of sync: rising when `i_sync_fall`=0 and falling when `i_sync_fall`=1. The opposite transition, which ends the pulse, starts nothing.
- R2: With `i_mode_lr`=1 (word-select mode), every sync transition starts a word, whatever the value of `i_sync_fall`.
- R3: Let k be the rising serial-clock edge at which a start transition is seen. The first bit is taken `i_start_dly` half-cycles after k (codes 0 to 4 give 0 to 4 half-cycles; codes 5 to 7 act as 4). Each following bit is taken one full serial-clock cycle after the previous one, so an odd delay takes bits on falling edges.
- R4: With `i_lsb_first`=0, the first received bit lands in bit W-1 of the word. With `i_lsb_first`=1, it lands in bit 0.
- R5: After W bits, the lane raises `o_valid` for exactly one `clk` cycle, with the word on its W-bit slice of `o_data`. Lane n uses bits n*W+W-1 down to n*W.
- R6: With `i_two_lanes`=0, lane 1 never raises `o_valid[1]`, and lane 0 works as usual.
- R7: With `i_two_lanes`=1, both lanes take bits at the same moments and raise their valids in the same cycle, each carrying the word from its own data line.
- R8: A start transition that arrives while a word is still being received is a framing error. It can arrive during the start delay or before the last bit. The partial word is dropped and never output, the new frame is received normally, and `o_frame_err` goes high and stays high until reset.
- R9: `i_end_dly` sets a guard window after the edge of a word's last bit. Codes 0 to 5 mean 0, 1, 2, 3, 4 and 6 half-cycles, and codes 6 and 7 act as 5. A start transition fewer than that many half-cycles after the last-bit edge is a framing error, as in R8. A start at or beyond the window is not. A start on the last-bit edge itself is legal when the start delay is non-zero.
- R10: While `rst_n` is low, `o_valid` is all zero and `o_frame_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_sclk | input | 1 | Serial clock from the tuner |
| i_sync | input | 1 | Frame pulse or word-select line from the tuner |
| i_dat | input | 2 | Serial data; bit 0 feeds lane 0, bit 1 feeds lane 1 |
| i_mode_lr | input | 1 | 0 = frame-pulse mode, 1 = word-select mode |
| i_sync_fall | input | 1 | In frame-pulse mode, 1 selects the falling transition as marker |
| i_lsb_first | input | 1 | 1 = first bit is the word LSB |
| i_start_dly | input | 3 | Start delay code, in half serial-clock cycles |
| i_end_dly | input | 3 | Guard window code after the last bit |
| i_two_lanes | input | 1 | 1 = both lanes active, 0 = lane 0 only |
| o_valid | output | 2 | One-cycle word strobe per lane |
| o_data | output | 2*W | Received words, lane n in bits n*W+W-1 down to n*W |
| o_frame_err | output | 1 | Sticky framing-error flag |

## Verification
The checker watches on every cycle that each valid is a single-cycle pulse and that lane 1 stays silent in single-lane mode. It also checks that the two lanes strobe together in dual-lane mode, that the error flag never drops outside reset, and that reset clears the outputs. Only the bench scenarios can show whether the right bits were taken and in the right order. They cover the start delay landing on rising or falling edges, marker selection in pulse mode, use of both transitions in word-select mode, and the guard window boundary, where one half-cycle separates a legal start from a framing error.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_RECV,
    ST_GUARD
  } ssr_state_t;

  // start delay code -> half cycles (saturates at 4)
  function automatic logic [2:0] start_halves(input logic [2:0] code);
    return (code > 3'd4) ? 3'd4 : code;
  endfunction

  // guard code -> half cycles: 0,1,2,3,4,6 ; codes above 5 act as 5
  function automatic logic [2:0] guard_halves(input logic [2:0] code);
    return (code >= 3'd5) ? 3'd6 : code;
  endfunction
endpackage

// File: rtl/ssr_front.sv
module ssr_front #(
  parameter int NDAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_sclk,
  input  logic            i_sync,
  input  logic [NDAT-1:0] i_dat,
  input  logic            i_mode_lr,
  input  logic            i_sync_fall,
  output logic            o_edge,
  output logic            o_start,
  output logic [NDAT-1:0] o_dat
);
  logic            sclk_m, sclk_s, sclk_q;
  logic            sync_m, sync_s, sync_prev, primed;
  logic [NDAT-1:0] dat_m, dat_s;
  logic            rise, fall, marker;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_m    <= 1'b0;
      sclk_s    <= 1'b0;
      sclk_q    <= 1'b0;
      sync_m    <= 1'b0;
      sync_s    <= 1'b0;
      sync_prev <= 1'b0;
      primed    <= 1'b0;
      dat_m     <= '0;
      dat_s     <= '0;
    end else begin
      sclk_m <= i_sclk;
      sclk_s <= sclk_m;
      sclk_q <= sclk_s;
      sync_m <= i_sync;
      sync_s <= sync_m;
      dat_m  <= i_dat;
      dat_s  <= dat_m;
      if (rise) begin
        sync_prev <= sync_s;
        primed    <= 1'b1;
      end
    end
  end

  always_comb begin
    if (i_mode_lr)        marker = sync_s ^ sync_prev;
    else if (i_sync_fall) marker = sync_prev & ~sync_s;
    else                  marker = ~sync_prev & sync_s;
  end

  assign o_start = rise & primed & marker;
  assign o_edge  = rise | fall;
  assign o_dat   = dat_s;
endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       i_edge,
  input  logic       i_start,
  input  logic [2:0] i_start_dly,
  input  logic [2:0] i_end_dly,
  output logic       o_cap,
  output logic       o_first,
  output logic       o_last,
  output logic       o_abort
);
  localparam int BW = (W > 2) ? $clog2(W) : 1;

  ssr_state_t  st, st_n;
  logic [2:0]  cnt, cnt_n, dly_h, grd_h;
  logic        ph, ph_n, old_last;
  logic [BW-1:0] bits, bits_n;

  assign dly_h = start_halves(i_start_dly);
  assign grd_h = guard_halves(i_end_dly);

  always_comb begin
    st_n = st; cnt_n = cnt; ph_n = ph; bits_n = bits;
    o_cap = 1'b0; o_first = 1'b0; o_last = 1'b0; o_abort = 1'b0;
    old_last = i_edge && (st == ST_RECV) && ph && (bits == BW'(W-1));
    if (i_start) begin
      o_abort = (st == ST_DELAY)
             || (st == ST_RECV && !(old_last && dly_h != 3'd0))
             || (st == ST_GUARD && cnt != 3'd1);
      if (dly_h == 3'd0) begin
        o_cap = 1'b1; o_first = 1'b1;
        st_n = ST_RECV; ph_n = 1'b0; bits_n = BW'(1);
      end else begin
        o_cap = old_last; o_last = old_last;
        st_n = ST_DELAY; cnt_n = dly_h;
      end
    end else if (i_edge) begin
      case (st)
        ST_DELAY: begin
          if (cnt == 3'd1) begin
            o_cap = 1'b1; o_first = 1'b1;
            st_n = ST_RECV; ph_n = 1'b0; bits_n = BW'(1);
          end else cnt_n = cnt - 3'd1;
        end
        ST_RECV: begin
          if (ph) begin
            o_cap = 1'b1; ph_n = 1'b0; bits_n = bits + BW'(1);
            if (bits == BW'(W-1)) begin
              o_last = 1'b1;
              if (grd_h == 3'd0) st_n = ST_IDLE;
              else begin st_n = ST_GUARD; cnt_n = grd_h; end
            end
          end else ph_n = 1'b1;
        end
        ST_GUARD: begin
          if (cnt == 3'd1) st_n = ST_IDLE;
          else cnt_n = cnt - 3'd1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; ph <= 1'b0; bits <= '0;
    end else begin
      st <= st_n; cnt <= cnt_n; ph <= ph_n; bits <= bits_n;
    end
  end
endmodule

// File: rtl/ssr_lane.sv
module ssr_lane #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         i_cap,
  input  logic         i_first,
  input  logic         i_last,
  input  logic         i_en,
  input  logic         i_lsb_first,
  input  logic         i_bit,
  output logic         o_valid,
  output logic [W-1:0] o_word
);
  logic [W-1:0] sh, nxt;

  always_comb begin
    if (i_first)          nxt = i_lsb_first ? {i_bit, {(W-1){1'b0}}} : {{(W-1){1'b0}}, i_bit};
    else if (i_lsb_first) nxt = {i_bit, sh[W-1:1]};
    else                  nxt = {sh[W-2:0], i_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; o_valid <= 1'b0; o_word <= '0;
    end else begin
      if (i_cap) sh <= nxt;
      o_valid <= i_cap && i_last && i_en;
      if (i_cap && i_last && i_en) o_word <= nxt;
    end
  end
endmodule

// File: rtl/serial_sample_rx.sv
module serial_sample_rx
  import ssr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_sclk,
  input  logic             i_sync,
  input  logic [LANES-1:0] i_dat,
  input  logic             i_mode_lr,
  input  logic             i_sync_fall,
  input  logic             i_lsb_first,
  input  logic [2:0]       i_start_dly,
  input  logic [2:0]       i_end_dly,
  input  logic             i_two_lanes,
  output logic [LANES-1:0]   o_valid,
  output logic [LANES*W-1:0] o_data,
  output logic             o_frame_err
);
  logic             edge_s, start_s, cap, first, last, abort;
  logic [LANES-1:0] dat_s;

  ssr_front #(.NDAT(LANES)) u_front (
    .clk(clk), .rst_n(rst_n), .i_sclk(i_sclk), .i_sync(i_sync), .i_dat(i_dat),
    .i_mode_lr(i_mode_lr), .i_sync_fall(i_sync_fall),
    .o_edge(edge_s), .o_start(start_s), .o_dat(dat_s)
  );

  ssr_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .i_edge(edge_s), .i_start(start_s),
    .i_start_dly(i_start_dly), .i_end_dly(i_end_dly),
    .o_cap(cap), .o_first(first), .o_last(last), .o_abort(abort)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ssr_lane #(.W(W)) u_lane (
      .clk(clk), .rst_n(rst_n), .i_cap(cap), .i_first(first), .i_last(last),
      .i_en((g == 0) ? 1'b1 : i_two_lanes), .i_lsb_first(i_lsb_first),
      .i_bit(dat_s[g]), .o_valid(o_valid[g]), .o_word(o_data[g*W +: W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_frame_err <= 1'b0;
    else if (abort) o_frame_err <= 1'b1;
  end
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       i_two_lanes,
  input logic [1:0] o_valid,
  input logic       o_frame_err
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (o_valid == 2'b00 && !o_frame_err)); // R10
  AST_PULSE_LANE0: assert property (@(posedge clk) disable iff (!rst_n) o_valid[0] |=> !o_valid[0]); // R5
  AST_PULSE_LANE1: assert property (@(posedge clk) disable iff (!rst_n) o_valid[1] |=> !o_valid[1]); // R5
  AST_LANE1_OFF: assert property (@(posedge clk) disable iff (!rst_n) !i_two_lanes |-> !o_valid[1]); // R6
  AST_LANES_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) i_two_lanes |-> (o_valid[0] == o_valid[1])); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) o_frame_err |=> o_frame_err); // R8
endmodule

bind serial_sample_rx ssr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .i_two_lanes(i_two_lanes),
  .o_valid(o_valid), .o_frame_err(o_frame_err)
);

// File: tb/test_serial_sample_rx.sv
module test_serial_sample_rx;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sync = 1'b0;
  logic [1:0] dat = 2'b00;
  logic mode_lr = 1'b1, sync_fall = 1'b0, lsb = 1'b0, two = 1'b0;
  logic [2:0] sdly = 3'd2, edly = 3'd0;
  logic [1:0] valid;
  logic [2*W-1:0] data;
  logic ferr;

  int n_checks = 0, n_err = 0, idx = 0;
  bit done = 0;
  logic cur_sync = 1'b0;
  string cur_req = "R5";
  logic [W-1:0] q0[$], q1[$];

  always #4 clk = ~clk;

  serial_sample_rx #(.W(W)) i_serial_sample_rx (
    .clk(clk), .rst_n(rst_n), .i_sclk(sclk), .i_sync(sync), .i_dat(dat),
    .i_mode_lr(mode_lr), .i_sync_fall(sync_fall), .i_lsb_first(lsb),
    .i_start_dly(sdly), .i_end_dly(edly), .i_two_lanes(two),
    .o_valid(valid), .o_data(data), .o_frame_err(ferr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid[0]) begin
        if (q0.size() == 0) chk(0, {cur_req, " lane0 unexpected word"}, {16'd0, data[W-1:0]}, 32'd0);
        else begin
          logic [W-1:0] e0;
          e0 = q0.pop_front();
          chk(data[W-1:0] == e0, {cur_req, " lane0 word"}, {16'd0, data[W-1:0]}, {16'd0, e0});
        end
      end
      if (valid[1]) begin
        if (q1.size() == 0) chk(0, {cur_req, " R6 lane1 unexpected word"}, {16'd0, data[2*W-1:W]}, 32'd0);
        else begin
          logic [W-1:0] e1;
          e1 = q1.pop_front();
          chk(data[2*W-1:W] == e1, {cur_req, " R7 lane1 word"}, {16'd0, data[2*W-1:W]}, {16'd0, e1});
        end
      end
    end
  end

  task automatic half(input logic s, input logic a, input logic b);
    repeat (2) @(negedge clk);
    sync = s; dat = {b, a};
    repeat (2) @(negedge clk);
    sclk = ~sclk;
    idx++;
  endtask

  function automatic logic idle_lvl();
    return mode_lr ? cur_sync : sync_fall;
  endfunction

  function automatic logic ser(input logic [W-1:0] w, input int b);
    return lsb ? w[b] : w[W-1-b];
  endfunction

  task automatic do_reset(input bit m, input bit sf, input bit l, input bit tw,
                          input logic [2:0] sd, input logic [2:0] ed);
    rst_n = 1'b0;
    @(negedge clk);
    mode_lr = m; sync_fall = sf; lsb = l; two = tw; sdly = sd; edly = ed;
    cur_sync = m ? 1'b0 : sf;
    sclk = 1'b0; idx = 0; sync = cur_sync; dat = 2'b00;
    repeat (4) @(negedge clk);
    chk(valid == 2'b00 && ferr == 1'b0, "R10 reset outputs", {30'd0, valid}, 32'd0);
    rst_n = 1'b1;
    half(cur_sync, 1'b0, 1'b0);
    half(cur_sync, 1'b0, 1'b0);
  endtask

  // one frame: nbits bits per lane, then at least gap halves before the next rise
  task automatic frame(input logic [W-1:0] w0, input logic [W-1:0] w1,
                       input int nbits, input int gap, input bit expect_out);
    int dh, last_i;
    dh = (sdly > 3'd4) ? 4 : int'(sdly);
    last_i = dh + 2 * (nbits - 1);
    if (expect_out) begin
      q0.push_back(w0);
      if (two) q1.push_back(w1);
    end
    if (mode_lr) cur_sync = ~cur_sync;
    for (int i = 0; i <= last_i; i++) begin
      logic s, a, b;
      int bi;
      s = mode_lr ? cur_sync : ((i == 0) ? ~sync_fall : sync_fall);
      bi = (i >= dh) ? (i - dh) / 2 : 0;
      if (i >= dh && ((i - dh) % 2) == 0) begin
        a = ser(w0, bi); b = ser(w1, bi);
      end else begin
        a = ~ser(w0, bi); b = ~ser(w1, bi);
      end
      half(s, a, b);
    end
    for (int j = 0; j < gap; j++) half(idle_lvl(), 1'b0, 1'b0);
    if (idx % 2 == 1) half(idle_lvl(), 1'b0, 1'b0);
  endtask

  task automatic drain(input string req);
    repeat (4) half(idle_lvl(), 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk(q0.size() == 0 && q1.size() == 0, {req, " all expected words seen"},
        q0.size() + q1.size(), 32'd0);
    q0.delete(); q1.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);

    // R1: pulse mode, rising marker, MSB first, delay 2, one lane (R6)
    cur_req = "R1";
    do_reset(0, 0, 0, 0, 3'd2, 3'd0);
    frame(16'hA5C3, 16'h1234, W, 2, 1);
    frame(16'h0F0F, 16'hFFFF, W, 2, 1);
    drain("R1 R6");
    chk(ferr == 1'b0, "R1 trailing pulse edge starts no frame", {31'd0, ferr}, 32'd0);

    // R1: falling marker, delay 0
    cur_req = "R1 R3";
    do_reset(0, 1, 0, 1, 3'd0, 3'd0);
    frame(16'h8001, 16'h7FFE, W, 2, 1);
    frame(16'h3C5A, 16'hC3A5, W, 2, 1);
    drain("R1 R3");
    chk(ferr == 1'b0, "R1 falling marker no error", {31'd0, ferr}, 32'd0);

    // R3/R4: delay 1 (falling-edge capture), LSB first, two lanes (R7)
    cur_req = "R3 R4";
    do_reset(0, 0, 1, 1, 3'd1, 3'd0);
    frame(16'h0001, 16'h8000, W, 2, 1);
    frame(16'hBEEF, 16'h1357, W, 2, 1);
    drain("R3 R4 R7");

    // R2: word-select, delay 3, both transitions, falling-marker pin ignored
    cur_req = "R2";
    do_reset(1, 1, 0, 1, 3'd3, 3'd0);
    frame(16'h1111, 16'h2222, W, 1, 1);
    frame(16'hDEAD, 16'hCAFE, W, 1, 1);
    frame(16'h6A6A, 16'h9595, W, 1, 1);
    drain("R2");
    chk(ferr == 1'b0, "R2 no framing error", {31'd0, ferr}, 32'd0);

    // R3: delay code 7 acts as 4
    cur_req = "R3";
    do_reset(1, 0, 1, 0, 3'd7, 3'd0);
    frame(16'h4C21, 16'h0000, W, 1, 1);
    frame(16'hF00D, 16'h0000, W, 1, 1);
    drain("R3 saturated delay");

    // R8: partial word dropped, new frame received, sticky flag
    cur_req = "R8";
    do_reset(0, 0, 0, 1, 3'd2, 3'd0);
    frame(16'h5555, 16'hAAAA, 5, 0, 0);
    frame(16'h9ABC, 16'h1F2E, W, 2, 1);
    drain("R8");
    chk(ferr == 1'b1, "R8 framing error raised", {31'd0, ferr}, 32'd1);
    frame(16'h7777, 16'h8888, W, 2, 1);
    drain("R8 after error");
    chk(ferr == 1'b1, "R8 flag stays set", {31'd0, ferr}, 32'd1);

    // R9: guard 2 halves, next start 2 halves after last bit -> legal
    cur_req = "R9";
    do_reset(0, 0, 0, 0, 3'd2, 3'd2);
    frame(16'h2468, 16'h0000, W, 1, 1);
    frame(16'h1357, 16'h0000, W, 1, 1);
    drain("R9 guard met");
    chk(ferr == 1'b0, "R9 start at guard limit is legal", {31'd0, ferr}, 32'd0);

    // R9: guard 3 halves, same spacing -> error, new frame still taken
    do_reset(0, 0, 0, 0, 3'd2, 3'd3);
    frame(16'hAAAA, 16'h0000, W, 1, 1);
    frame(16'hCCCC, 16'h0000, W, 1, 1);
    drain("R9 guard short");
    chk(ferr == 1'b1, "R9 start inside guard flagged", {31'd0, ferr}, 32'd1);

    // R9: code 6 acts as 6 halves
    do_reset(0, 0, 0, 0, 3'd2, 3'd6);
    frame(16'h0BAD, 16'h0000, W, 5, 1);
    frame(16'hF1F1, 16'h0000, W, 5, 1);
    drain("R9 code 6");
    chk(ferr == 1'b0, "R9 code 6 spacing legal", {31'd0, ferr}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule